// File: doc/BRIEF.md
# Protected Clock Source Switch

This block chooses which of four clock sources drives the system clock and divides the chosen source down to an output clock enable. Each source is represented by three inputs: an enable, a stable flag and a tick that pulses once per source period in the system clock domain. A small register write port programs the block. The divide value can be written at any time. The 3-bit source select is guarded by a write-protection lock that opens only after a fixed three-byte key.

When an unlocked write asks for a new source, the block checks the request before accepting it. The code must be a defined one. The target source must be enabled and stable. The source now in use must also be enabled. If any of these checks fails, the write is refused and a sticky fail flag is raised. An accepted request is held as pending and takes effect on the next pulse of the divided output, so no output period is cut short.

Status is always visible on a separate output. It carries the per-source stable flags and the fail flag. At reset the select field loads from a configuration input, which picks either the crystal or the fast internal oscillator.

Top module: `clksw_top`

## Requirements
- R1: Asynchronous reset sets the select to 111 when cfg_hirc_i is 1 and to 000 when it is 0. Reset also clears the fail flag and the divide value, and leaves the lock closed.
- R2: The lock opens only after the writes 59h, 16h and 88h reach address 0 consecutively, in that order. Any other value written to address 0 during the sequence returns it to the start. Any write to address 0 while open closes the lock.
- R3: A write to the select register (address 1) while the lock is closed has no effect on the selection and does not raise the fail flag.
- R4: Select codes are 000 crystal (source 0), 010 PLL (source 1), 011 slow internal oscillator (source 2) and 111 fast internal oscillator (source 3). An unlocked write of any other code is refused and sets the fail flag.
- R5: An unlocked select write is refused, with the fail flag set and the selection kept, when the target is not stable, the target is not enabled, or the current source is not enabled.
- R6: The fail flag is status bit 7. Writing a byte with bit 7 set to address 3 clears it. Writing a byte with bit 7 clear leaves it unchanged.
- R7: status_o bits 0, 2, 3 and 4 show the stable inputs of sources 0, 1, 2 and 3. Bits 1, 5 and 6 read 0.
- R8: The divide value N (address 2, bits 3:0) makes clk_en_o pulse once every N+1 ticks of the selected source. A new N takes effect at the next output pulse.
- R9: An accepted source change appears on sel_o only in the cycle in which clk_en_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_hirc_i | input | 1 | Reset choice for the select: 1 gives 111, 0 gives 000 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 lock key, 1 select, 2 divide, 3 status |
| wr_data_i | input | 8 | Write data |
| src_en_i | input | 4 | Per-source enable |
| src_stable_i | input | 4 | Per-source stable flag |
| src_tick_i | input | 4 | Per-source tick, one pulse per source period |
| clk_en_o | output | 1 | Divided output clock enable |
| sel_o | output | 3 | Active source select code |
| div_o | output | 4 | Programmed divide value |
| unlocked_o | output | 1 | Lock is open |
| status_o | output | 8 | Stable flags and fail flag |

## Verification
The hardest case to reach is a switch that is accepted but still waiting. To see it, the divided output must run slowly enough that the bench can watch the gap between acceptance and the next output pulse. The bench sets a divide of 15 on the crystal and lines up on one clk_en_o pulse. It then writes the new select, confirms that sel_o still holds the old code a few cycles later, and finally checks that the change appears on the next pulse. Refusal because the current source is disabled is reached by dropping the enable of the source in use while its ticks keep running.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int NSRC    = 4;
  localparam int SEL_W   = 3;
  localparam int DIV_W   = 4;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int STAT_W  = 8;
  localparam int FAIL_BIT = 7;
  localparam int IDX_W   = $clog2(NSRC);

  typedef enum logic [ADDR_W-1:0] {
    A_KEY  = 2'd0,
    A_SEL  = 2'd1,
    A_DIV  = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    U_IDLE = 2'd0,
    U_K1   = 2'd1,
    U_K2   = 2'd2,
    U_OPEN = 2'd3
  } unl_st_e;

  localparam logic [7:0] KEY0 = 8'h59;
  localparam logic [7:0] KEY1 = 8'h16;
  localparam logic [7:0] KEY2 = 8'h88;

  localparam logic [SEL_W-1:0] SEL_XT   = 3'b000;
  localparam logic [SEL_W-1:0] SEL_PLL  = 3'b010;
  localparam logic [SEL_W-1:0] SEL_LIRC = 3'b011;
  localparam logic [SEL_W-1:0] SEL_HIRC = 3'b111;

  function automatic logic code_valid(input logic [SEL_W-1:0] c);
    return (c == SEL_XT) || (c == SEL_PLL) || (c == SEL_LIRC) || (c == SEL_HIRC);
  endfunction

  function automatic logic [IDX_W-1:0] code_idx(input logic [SEL_W-1:0] c);
    case (c)
      SEL_XT:   return IDX_W'(0);
      SEL_PLL:  return IDX_W'(1);
      SEL_LIRC: return IDX_W'(2);
      default:  return IDX_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/clksw_unlock.sv
module clksw_unlock
  import clksw_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_wr_i,
  input  logic [DW-1:0] data_i,
  output logic          open_o
);
  unl_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= U_IDLE;
    end else if (key_wr_i) begin
      unique case (st_q)
        U_IDLE:  st_q <= (data_i == DW'(KEY0)) ? U_K1   : U_IDLE;
        U_K1:    st_q <= (data_i == DW'(KEY1)) ? U_K2   : U_IDLE;
        U_K2:    st_q <= (data_i == DW'(KEY2)) ? U_OPEN : U_IDLE;
        default: st_q <= U_IDLE;
      endcase
    end
  end

  assign open_o = (st_q == U_OPEN);

  // R2: opening always follows the final key byte
  a_r2_open_after_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(key_wr_i && (data_i == DW'(KEY2))));

  // R2: any key write while open closes the lock
  a_r2_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && key_wr_i) |=> !open_o);
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int NS = NSRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_hirc_i,
  input  logic          sel_wr_i,
  input  logic [SW-1:0] sel_data_i,
  input  logic          clr_i,
  input  logic          unlocked_i,
  input  logic [NS-1:0] src_en_i,
  input  logic [NS-1:0] src_stable_i,
  input  logic          boundary_i,
  output logic [SW-1:0] sel_o,
  output logic          fail_o
);
  logic [SW-1:0]    sel_q, pend_q;
  logic             pend_vld_q, fail_q;
  logic [IDX_W-1:0] cur_idx, tgt_idx;
  logic             req, accept;

  assign cur_idx = code_idx(sel_q);
  assign tgt_idx = code_idx(sel_data_i);
  assign req     = sel_wr_i && unlocked_i;
  assign accept  = code_valid(sel_data_i) && src_stable_i[tgt_idx]
                   && src_en_i[tgt_idx] && src_en_i[cur_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= cfg_hirc_i ? SEL_HIRC : SEL_XT;
      pend_q     <= SEL_XT;
      pend_vld_q <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      if (clr_i) fail_q <= 1'b0;
      if (req) begin
        if (accept) begin
          pend_q     <= sel_data_i;
          pend_vld_q <= 1'b1;
        end else begin
          fail_q <= 1'b1;
        end
      end else if (pend_vld_q && boundary_i) begin
        sel_q      <= pend_q;
        pend_vld_q <= 1'b0;
      end
    end
  end

  assign sel_o  = sel_q;
  assign fail_o = fail_q;

  // R4: the active selection never holds a reserved code
  a_r4_sel_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid(sel_q));

  // R4: reserved code write while unlocked raises the flag
  a_r4_reserved_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && !code_valid(sel_data_i)) |=> fail_o);

  // R5: request toward an unstable source raises the flag
  a_r5_unstable_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && !src_stable_i[tgt_idx]) |=> fail_o);

  // R3: locked select write leaves flag and selection alone
  a_r3_locked_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr_i && !unlocked_i && !pend_vld_q) |=> ($stable(sel_q) && $stable(fail_q)));
endmodule

// File: rtl/clksw_div.sv
module clksw_div
  import clksw_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          div_wr_i,
  input  logic [DW-1:0] div_data_i,
  output logic [DW-1:0] div_o,
  output logic          boundary_o,
  output logic          clk_en_o
);
  logic [DW-1:0] cnt_q, div_act_q, div_q;
  logic          en_q;

  assign boundary_o = tick_i && (cnt_q == div_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      div_act_q <= '0;
      div_q     <= '0;
      en_q      <= 1'b0;
    end else begin
      if (div_wr_i) div_q <= div_data_i;
      if (tick_i) begin
        if (boundary_o) begin
          cnt_q     <= '0;
          div_act_q <= div_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      en_q <= boundary_o;
    end
  end

  assign div_o    = div_q;
  assign clk_en_o = en_q;

  // R8: counter stays within the active divide range
  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_act_q);

  // R8: no output pulse without a source tick in the previous cycle
  a_r8_pulse_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> $past(tick_i));
endmodule

// File: rtl/clksw_top.sv
module clksw_top
  import clksw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_hirc_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NSRC-1:0]   src_en_i,
  input  logic [NSRC-1:0]   src_stable_i,
  input  logic [NSRC-1:0]   src_tick_i,
  output logic              clk_en_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              unlocked_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int STB_POS [NSRC] = '{0, 2, 3, 4};

  logic key_wr, sel_wr, div_wr, clr;
  logic unlocked, fail, boundary, tick_sel;
  logic [SEL_W-1:0] sel;

  assign key_wr = wr_en_i && (wr_addr_i == A_KEY);
  assign sel_wr = wr_en_i && (wr_addr_i == A_SEL);
  assign div_wr = wr_en_i && (wr_addr_i == A_DIV);
  assign clr    = wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[FAIL_BIT];

  clksw_unlock #(.DW(DATA_W)) u_unlock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .key_wr_i(key_wr),
    .data_i  (wr_data_i),
    .open_o  (unlocked)
  );

  clksw_ctrl #(.SW(SEL_W), .NS(NSRC)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_hirc_i  (cfg_hirc_i),
    .sel_wr_i    (sel_wr),
    .sel_data_i  (wr_data_i[SEL_W-1:0]),
    .clr_i       (clr),
    .unlocked_i  (unlocked),
    .src_en_i    (src_en_i),
    .src_stable_i(src_stable_i),
    .boundary_i  (boundary),
    .sel_o       (sel),
    .fail_o      (fail)
  );

  assign tick_sel = src_tick_i[code_idx(sel)];

  clksw_div #(.DW(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_sel),
    .div_wr_i  (div_wr),
    .div_data_i(wr_data_i[DIV_W-1:0]),
    .div_o     (div_o),
    .boundary_o(boundary),
    .clk_en_o  (clk_en_o)
  );

  always_comb begin
    status_o = '0;
    for (int i = 0; i < NSRC; i++) status_o[STB_POS[i]] = src_stable_i[i];
    status_o[FAIL_BIT] = fail;
  end

  assign sel_o      = sel;
  assign unlocked_o = unlocked;

  // R9: selection moves only together with an output pulse
  a_r9_switch_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_o) |-> clk_en_o);

  // R6: a clearing status write drops the flag unless a refusal lands
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !status_o[FAIL_BIT]);
endmodule

// File: tb/tb_clksw_top.sv
module tb_clksw_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;
  // {addr[14:13], data[12:5], exp_unlocked[4], exp_sel[3:1], exp_fail[0]}
  localparam logic [14:0] VEC [NV] = '{
    {2'd1, 8'h07, 1'b0, 3'd0, 1'b0},
    {2'd0, 8'h59, 1'b0, 3'd0, 1'b0},
    {2'd0, 8'h16, 1'b0, 3'd0, 1'b0},
    {2'd0, 8'h88, 1'b1, 3'd0, 1'b0},
    {2'd1, 8'h07, 1'b1, 3'd7, 1'b0},
    {2'd1, 8'h03, 1'b1, 3'd7, 1'b1},
    {2'd3, 8'h7F, 1'b1, 3'd7, 1'b1},
    {2'd3, 8'h80, 1'b1, 3'd7, 1'b0},
    {2'd1, 8'h05, 1'b1, 3'd7, 1'b1},
    {2'd3, 8'h80, 1'b1, 3'd7, 1'b0},
    {2'd0, 8'h00, 1'b0, 3'd7, 1'b0},
    {2'd1, 8'h02, 1'b0, 3'd7, 1'b0},
    {2'd0, 8'h59, 1'b0, 3'd7, 1'b0},
    {2'd0, 8'h88, 1'b0, 3'd7, 1'b0},
    {2'd0, 8'h16, 1'b0, 3'd7, 1'b0},
    {2'd1, 8'h00, 1'b0, 3'd7, 1'b0},
    {2'd0, 8'h59, 1'b0, 3'd7, 1'b0},
    {2'd0, 8'h16, 1'b0, 3'd7, 1'b0},
    {2'd0, 8'h88, 1'b1, 3'd7, 1'b0},
    {2'd1, 8'h02, 1'b1, 3'd2, 1'b0},
    {2'd1, 8'h00, 1'b1, 3'd0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_hirc = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] src_en = 4'hF;
  logic [3:0] src_stable = 4'b1011;
  logic [3:0] src_tick;
  logic       clk_en;
  logic [2:0] sel;
  logic [3:0] div;
  logic       unlocked;
  logic [7:0] status;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;
  assign src_tick = {(cyc % 3) == 0, (cyc % 4) == 0, (cyc % 2) == 0, 1'b1};

  clksw_top dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_hirc_i(cfg_hirc),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .src_en_i(src_en), .src_stable_i(src_stable), .src_tick_i(src_tick),
    .clk_en_o(clk_en), .sel_o(sel), .div_o(div),
    .unlocked_o(unlocked), .status_o(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_en();
    do @(negedge clk); while (!clk_en);
  endtask

  task automatic period(output int n);
    wait_en(); wait_en();
    n = 0;
    do begin @(negedge clk); n++; end while (!clk_en);
  endtask

  task automatic do_reset(input logic hirc);
    cfg_hirc = hirc;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  initial begin
    int p;
    do_reset(1'b0);
    // R1 reset state with crystal default
    check("R1 sel", sel, 3'd0);
    check("R1 unlocked", unlocked, 0);
    check("R1 div", div, 0);
    check("R7 status", status, 8'h15);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][14:13], VEC[i][12:5]);
      idle(12);
      check($sformatf("R2 vec%0d unlocked", i), unlocked, VEC[i][4]);
      check($sformatf("R3/R4 vec%0d sel", i), sel, VEC[i][3:1]);
      check($sformatf("R5/R6 vec%0d fail", i), status[7], VEC[i][0]);
    end

    // R8 divide on crystal: period 4
    wr(2'd2, 8'h03);
    check("R8 div_o", div, 4'd3);
    period(p);
    check("R8 xtal div3 period", p, 4);
    // R8 PLL ticks every 2: period 8, then 2
    wr(2'd1, 8'h02);
    idle(30);
    check("R8 sel pll", sel, 3'd2);
    period(p);
    check("R8 pll div3 period", p, 8);
    wr(2'd2, 8'h00);
    period(p);
    check("R8 pll div0 period", p, 2);

    // R5 target disabled
    src_en = 4'b0111;
    wr(2'd1, 8'h07);
    idle(10);
    check("R5 target off sel", sel, 3'd2);
    check("R5 target off fail", status[7], 1);
    src_en = 4'hF;
    wr(2'd3, 8'h80);
    // R5 current source disabled
    src_en = 4'b1101;
    wr(2'd1, 8'h00);
    idle(10);
    check("R5 current off sel", sel, 3'd2);
    check("R5 current off fail", status[7], 1);
    src_en = 4'hF;
    wr(2'd3, 8'h80);
    check("R6 cleared", status[7], 0);

    // R9 switch waits for the output pulse
    wr(2'd1, 8'h00);
    idle(10);
    check("R9 back to xtal", sel, 3'd0);
    wr(2'd2, 8'h0F);
    idle(40);
    wait_en();
    wr(2'd1, 8'h07);
    idle(4);
    check("R9 pending held", sel, 3'd0);
    wait_en();
    check("R9 applied at pulse", sel, 3'd7);

    // R1 reset with fast oscillator default
    do_reset(1'b1);
    check("R1 hirc sel", sel, 3'd7);
    check("R1 relocked", unlocked, 0);
    check("R1 fail clear", status[7], 0);
    check("R1 div cleared", div, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule